// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the operand bytes of an instruction and the processor's register state into a 24-bit effective address. It supports sixteen addressing modes. The register state is the direct-page base, the two index registers, the stack pointer, the updated program counter and the data and program bank registers. Some modes go through a pointer in memory. For those, a sequencer outside the unit reads the 16-bit pointer word and, for long pointers, the bank byte that follows it. It supplies them as inputs together with the start strobe. The unit also reports where that pointer lives, whether the pointer read wraps inside a 256-byte page or inside a 64 KiB bank, and how many extra cycles the access costs.

The direct-page wrap depends on the emulation flag and on whether the low byte of the direct-page base is zero. The extra-cycle count depends on the mode, on whether the access is a store, on the index width and on a carry out of the low address byte. Each result is captured one cycle after a start strobe. A done pulse marks that cycle, and the outputs hold until the next start.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 0 (absolute) gives `ea` = {`reg_db`, `op_hi`, `op_lo`} and an extra count of 0.
- R2: Mode codes 1 (absolute+X) and 2 (absolute+Y) add the effective index to {`reg_db`, `op_hi`, `op_lo`} modulo 2^24. When `idx8`=1 the effective index is the low byte of the register with its high byte taken as zero; when `idx8`=0 it is the full 16-bit register.
- R3: For modes 1, 2 and 8, one penalty cycle is counted when `is_write`=1, or when `idx8`=0, or when the base low byte plus the index low byte reaches 0x100. The base is the operand for modes 1 and 2 and `ptr_word` for mode 8.
- R4: Direct modes (codes 3 to 10) form `reg_d` + `op_lo` truncated to 16 bits in bank 0 (this is `ea` for code 3). Each of them counts one extra cycle when `reg_d[7:0]` is nonzero.
- R5: Codes 4 (direct+X) and 5 (direct+Y) add the effective index only to the low byte of the direct sum when `emu`=1 and `reg_d[7:0]`=0, which keeps bits 15:8. Otherwise they add the full 16-bit index modulo 2^16. The result is in bank 0, and one further cycle is always counted.
- R6: For codes 6 (direct indirect), 7 (direct indexed indirect) and 8 (direct indirect +Y), `ptr_addr` is the direct sum (code 7: the R5 result) in bank 0. `ptr_wrap_pg`=1 (page wrap) exactly when `emu`=1 and `reg_d[7:0]`=0; every other mode drives 0 (bank wrap).
- R7: Codes 6 and 7 give `ea` = {`reg_db`, `ptr_word`}. Code 7 counts one further fixed cycle. Code 8 gives {`reg_db`, `ptr_word`} plus the effective Y modulo 2^24.
- R8: Codes 9 (direct long indirect) and 10 (the same +Y) read the pointer at the direct sum. They give `ea` = {`ptr_bank`, `ptr_word`}, and for code 10 the effective Y is added modulo 2^24.
- R9: Code 11 (stack relative) gives `reg_s` + `op_lo` modulo 2^16 in bank 0 with an extra count of 1. Code 12 (stack relative indirect +Y) reads the pointer there and gives ({`reg_db`, `ptr_word`} + effective Y) modulo 2^24 with an extra count of 2.
- R10: Code 13 adds the sign-extended `op_lo` to `reg_pc`, and code 14 adds {`op_hi`, `op_lo`} to `reg_pc`. Both truncate to 16 bits, place the result in bank `reg_pb` and count 0.
- R11: Code 15 (absolute indexed indirect) gives `ptr_addr` = {`reg_pb`, ({`op_hi`,`op_lo`} + effective X) mod 2^16} and `ea` = {`reg_pb`, `ptr_word`}, with an extra count of 1.
- R12: `done` is high exactly in the cycle after a cycle with `start`=1. The outputs are updated only then and hold otherwise. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture a new computation |
| mode | input | 4 | Addressing mode code (see requirements) |
| is_write | input | 1 | Access is a store |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| ptr_word | input | 16 | Pointer word read by the sequencer |
| ptr_bank | input | 8 | Pointer bank byte for long pointers |
| reg_d | input | 16 | Direct-page base |
| reg_x | input | 16 | Index X |
| reg_y | input | 16 | Index Y |
| reg_s | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter after the operand |
| reg_db | input | 8 | Data bank |
| reg_pb | input | 8 | Program bank |
| emu | input | 1 | Emulation-mode flag |
| idx8 | input | 1 | Index registers are 8 bits wide |
| done | output | 1 | Result valid pulse |
| ea | output | 24 | Effective address |
| ptr_addr | output | 24 | Location of the pointer to read |
| ptr_wrap_pg | output | 1 | 1: pointer read wraps in page; 0: in bank |
| extra | output | 2 | Extra cycles to charge |

## Verification
The hardest case to reach is the page-wrapped direct index. It needs `emu` high, a direct base whose low byte is zero and an index low byte that carries past 0xFF, and uniform random stimulus almost never lines these up. The bench therefore forces the low byte of the direct base to zero in half of its random transactions. It also runs directed cases that push the low-byte sum across the page in both modes. Other directed cases drive the carry in the penalty test across 0x100 for each index width, and negative branch offsets that wrap below zero.

// File: rtl/ea_pkg.sv
// Shared widths, mode codes and result record for the address unit.
package ea_pkg;
    localparam int ADDR_W  = 24;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 4;
    localparam int EXTRA_W = 2;

    typedef enum logic [MODE_W-1:0] {
        EM_ABS      = 4'd0,
        EM_ABS_X    = 4'd1,
        EM_ABS_Y    = 4'd2,
        EM_DIR      = 4'd3,
        EM_DIR_X    = 4'd4,
        EM_DIR_Y    = 4'd5,
        EM_DIR_IND  = 4'd6,
        EM_DIRX_IND = 4'd7,
        EM_DIR_INDY = 4'd8,
        EM_DIR_LNG  = 4'd9,
        EM_DIR_LNGY = 4'd10,
        EM_STK      = 4'd11,
        EM_STK_INDY = 4'd12,
        EM_REL8     = 4'd13,
        EM_REL16    = 4'd14,
        EM_ABSX_IND = 4'd15
    } ea_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  ea;
        logic [ADDR_W-1:0]  ptr;
        logic               pg;
        logic [EXTRA_W-1:0] extra;
    } ea_result_t;
endpackage

// File: rtl/ea_index_narrow.sv
// Effective index: keeps the low NB bits only when the narrow flag is set.
// Assumes NB < W.
module ea_index_narrow #(
    parameter int W  = 16,
    parameter int NB = 8
) (
    input  logic [W-1:0] raw,
    input  logic         narrow,
    output logic [W-1:0] eff
);
    localparam int HI_W = W - NB;

    // Clear the upper part of the index when narrow.
    always_comb begin
        eff = narrow ? {{HI_W{1'b0}}, raw[NB-1:0]} : raw;
    end
endmodule

// File: rtl/ea_direct_calc.sv
// Direct-page sum and the direct indexed forms for both index registers.
// Page mode (emulation with zero base low byte) indexes inside the page only.
module ea_direct_calc #(
    parameter int W  = 16,
    parameter int NB = 8
) (
    input  logic [W-1:0]  base,
    input  logic [NB-1:0] off,
    input  logic [W-1:0]  idx_x,
    input  logic [W-1:0]  idx_y,
    input  logic          emu,
    output logic [W-1:0]  dsum,
    output logic [W-1:0]  dx,
    output logic [W-1:0]  dy,
    output logic          lo_nz,
    output logic          page_md
);
    localparam int HI_W = W - NB;

    logic [W-1:0] idx_a [2];
    logic [W-1:0] res_a [2];

    // Base plus operand, base low-byte test and the page-mode decision.
    always_comb begin
        dsum    = base + {{HI_W{1'b0}}, off};
        lo_nz   = |base[NB-1:0];
        page_md = emu & ~lo_nz;
        idx_a[0] = idx_x;
        idx_a[1] = idx_y;
    end

    for (genvar g = 0; g < 2; g++) begin : g_idx
        logic [NB-1:0] lo_sum;
        // Indexed direct address, page-local or full-width.
        always_comb begin
            lo_sum   = dsum[NB-1:0] + idx_a[g][NB-1:0];
            res_a[g] = page_md ? {dsum[W-1:NB], lo_sum} : (dsum + idx_a[g]);
        end
    end

    // Name the per-index results.
    always_comb begin
        dx = res_a[0];
        dy = res_a[1];
    end
endmodule

// File: rtl/ea_page_penalty.sv
// Indexed access penalty: store, wide index or carry out of the low byte.
module ea_page_penalty #(
    parameter int NB = 8
) (
    input  logic [NB-1:0] base_lo,
    input  logic [NB-1:0] idx_lo,
    input  logic          is_write,
    input  logic          narrow,
    output logic          pen
);
    logic [NB:0] lo_add;

    // Carry test plus the unconditional causes.
    always_comb begin
        lo_add = {1'b0, base_lo} + {1'b0, idx_lo};
        pen    = is_write | ~narrow | lo_add[NB];
    end
endmodule

// File: rtl/ea_gen_unit.sv
// Effective address unit: selects the mode result combinationally and
// registers it on start; done pulses one cycle later.
// Assumes pointer data is valid in the same cycle as start.
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int BW = BYTE_W,
    parameter int MW = MODE_W,
    parameter int XW = EXTRA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] mode,
    input  logic          is_write,
    input  logic [BW-1:0] op_lo,
    input  logic [BW-1:0] op_hi,
    input  logic [WW-1:0] ptr_word,
    input  logic [BW-1:0] ptr_bank,
    input  logic [WW-1:0] reg_d,
    input  logic [WW-1:0] reg_x,
    input  logic [WW-1:0] reg_y,
    input  logic [WW-1:0] reg_s,
    input  logic [WW-1:0] reg_pc,
    input  logic [BW-1:0] reg_db,
    input  logic [BW-1:0] reg_pb,
    input  logic          emu,
    input  logic          idx8,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ptr_addr,
    output logic          ptr_wrap_pg,
    output logic [XW-1:0] extra
);
    localparam int BANK_W = AW - WW;
    localparam int SEXT_W = WW - BW;

    logic [WW-1:0] idx_raw [2];
    logic [WW-1:0] idx_eff [2];
    logic [WW-1:0] xe, ye;

    // Collect the raw index registers.
    always_comb begin
        idx_raw[0] = reg_x;
        idx_raw[1] = reg_y;
    end

    for (genvar g = 0; g < 2; g++) begin : g_narrow
        ea_index_narrow #(.W(WW), .NB(BW)) u_narrow (
            .raw    (idx_raw[g]),
            .narrow (idx8),
            .eff    (idx_eff[g])
        );
    end

    // Name the effective indexes.
    always_comb begin
        xe = idx_eff[0];
        ye = idx_eff[1];
    end

    logic [WW-1:0] dsum, dx, dy;
    logic          d_nz, page_md;

    ea_direct_calc #(.W(WW), .NB(BW)) u_dir (
        .base    (reg_d),
        .off     (op_lo),
        .idx_x   (xe),
        .idx_y   (ye),
        .emu     (emu),
        .dsum    (dsum),
        .dx      (dx),
        .dy      (dy),
        .lo_nz   (d_nz),
        .page_md (page_md)
    );

    logic [BW-1:0] pen_base [2];
    logic [BW-1:0] pen_idx  [2];
    logic          pen_out  [2];

    // Penalty inputs: slot 0 is absolute+X, slot 1 is the Y-indexed forms.
    always_comb begin
        pen_base[0] = op_lo;
        pen_idx[0]  = xe[BW-1:0];
        pen_base[1] = (mode == EM_DIR_INDY) ? ptr_word[BW-1:0] : op_lo;
        pen_idx[1]  = ye[BW-1:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_pen
        ea_page_penalty #(.NB(BW)) u_pen (
            .base_lo  (pen_base[g]),
            .idx_lo   (pen_idx[g]),
            .is_write (is_write),
            .narrow   (idx8),
            .pen      (pen_out[g])
        );
    end

    logic [WW-1:0] op16, stk_sum, rel_off, absx16;
    logic [AW-1:0] db_abs, db_ptr, lng_ptr, xe24, ye24;
    logic [XW-1:0] d_cost;
    ea_result_t    res_d, res_q;

    // Operand words and bank-extended bases shared by several modes.
    always_comb begin
        op16    = {op_hi, op_lo};
        stk_sum = reg_s + {{SEXT_W{1'b0}}, op_lo};
        rel_off = {{SEXT_W{op_lo[BW-1]}}, op_lo};
        absx16  = op16 + xe;
        db_abs  = {reg_db, op16};
        db_ptr  = {reg_db, ptr_word};
        lng_ptr = {ptr_bank, ptr_word};
        xe24    = {{BANK_W{1'b0}}, xe};
        ye24    = {{BANK_W{1'b0}}, ye};
        d_cost  = {{(XW-1){1'b0}}, d_nz};
    end

    // Mode selection of address, pointer location, wrap kind and cost.
    always_comb begin
        res_d = '0;
        unique case (mode)
            EM_ABS: res_d.ea = db_abs;
            EM_ABS_X: begin
                res_d.ea    = db_abs + xe24;
                res_d.extra = {{(XW-1){1'b0}}, pen_out[0]};
            end
            EM_ABS_Y: begin
                res_d.ea    = db_abs + ye24;
                res_d.extra = {{(XW-1){1'b0}}, pen_out[1]};
            end
            EM_DIR: begin
                res_d.ea    = {{BANK_W{1'b0}}, dsum};
                res_d.extra = d_cost;
            end
            EM_DIR_X: begin
                res_d.ea    = {{BANK_W{1'b0}}, dx};
                res_d.extra = d_cost + XW'(1);
            end
            EM_DIR_Y: begin
                res_d.ea    = {{BANK_W{1'b0}}, dy};
                res_d.extra = d_cost + XW'(1);
            end
            EM_DIR_IND: begin
                res_d.ptr   = {{BANK_W{1'b0}}, dsum};
                res_d.pg    = page_md;
                res_d.ea    = db_ptr;
                res_d.extra = d_cost;
            end
            EM_DIRX_IND: begin
                res_d.ptr   = {{BANK_W{1'b0}}, dx};
                res_d.pg    = page_md;
                res_d.ea    = db_ptr;
                res_d.extra = d_cost + XW'(1);
            end
            EM_DIR_INDY: begin
                res_d.ptr   = {{BANK_W{1'b0}}, dsum};
                res_d.pg    = page_md;
                res_d.ea    = db_ptr + ye24;
                res_d.extra = d_cost + {{(XW-1){1'b0}}, pen_out[1]};
            end
            EM_DIR_LNG: begin
                res_d.ptr   = {{BANK_W{1'b0}}, dsum};
                res_d.ea    = lng_ptr;
                res_d.extra = d_cost;
            end
            EM_DIR_LNGY: begin
                res_d.ptr   = {{BANK_W{1'b0}}, dsum};
                res_d.ea    = lng_ptr + ye24;
                res_d.extra = d_cost;
            end
            EM_STK: begin
                res_d.ea    = {{BANK_W{1'b0}}, stk_sum};
                res_d.extra = XW'(1);
            end
            EM_STK_INDY: begin
                res_d.ptr   = {{BANK_W{1'b0}}, stk_sum};
                res_d.ea    = db_ptr + ye24;
                res_d.extra = XW'(2);
            end
            EM_REL8:  res_d.ea = {reg_pb, reg_pc + rel_off};
            EM_REL16: res_d.ea = {reg_pb, reg_pc + op16};
            EM_ABSX_IND: begin
                res_d.ptr   = {reg_pb, absx16};
                res_d.ea    = {reg_pb, ptr_word};
                res_d.extra = XW'(1);
            end
            default: res_d = '0;
        endcase
    end

    // Capture the result on start and raise done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                res_q <= res_d;
            end
        end
    end

    // Drive the ports from the held result.
    always_comb begin
        ea          = res_q.ea;
        ptr_addr    = res_q.ptr;
        ptr_wrap_pg = res_q.pg;
        extra       = res_q.extra;
    end
endmodule

// File: rtl/ea_gen_unit_chk.sv
// Temporal checks on the address unit's ports, bound to every instance.
module ea_gen_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  mode,
    input logic [7:0]  op_lo,
    input logic [7:0]  op_hi,
    input logic [15:0] reg_d,
    input logic [7:0]  reg_db,
    input logic [7:0]  reg_pb,
    input logic        emu,
    input logic        done,
    input logic [23:0] ea,
    input logic        ptr_wrap_pg,
    input logic [1:0]  extra
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R12
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R12
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(ea) && $stable(extra))); // R12
    AST_ABS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd0) |=> (ea == {$past(reg_db), $past(op_hi), $past(op_lo)})); // R1
    AST_DIR_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd3) |=> (extra == {1'b0, ($past(reg_d[7:0]) != 8'd0)})); // R4
    AST_DIRX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd4 && emu && reg_d[7:0] == 8'd0)
            |=> (ea[15:8] == $past(reg_d[15:8]) && ea[23:16] == 8'd0)); // R5
    AST_PAGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ptr_wrap_pg) |-> ($past(emu) && $past(reg_d[7:0]) == 8'd0)); // R6
    AST_STK_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd11) |=> (extra == 2'd1)); // R9
    AST_STKY_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd12) |=> (extra == 2'd2)); // R9
    AST_REL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (mode == 4'd13 || mode == 4'd14)) |=> (ea[23:16] == $past(reg_pb))); // R10
endmodule

bind ea_gen_unit ea_gen_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .op_lo       (op_lo),
    .op_hi       (op_hi),
    .reg_d       (reg_d),
    .reg_db      (reg_db),
    .reg_pb      (reg_pb),
    .emu         (emu),
    .done        (done),
    .ea          (ea),
    .ptr_wrap_pg (ptr_wrap_pg),
    .extra       (extra)
);

// File: tb/ea_gen_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference updated each rising edge, compared each falling edge.
module ea_gen_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        is_write = 1'b0;
    logic [7:0]  op_lo = '0, op_hi = '0, ptr_bank = '0, reg_db = '0, reg_pb = '0;
    logic [15:0] ptr_word = '0, reg_d = '0, reg_x = '0, reg_y = '0, reg_s = '0, reg_pc = '0;
    logic        emu = 1'b0, idx8 = 1'b0;
    logic        done, ptr_wrap_pg;
    logic [23:0] ea, ptr_addr;
    logic [1:0]  extra;

    int n_chk = 0;
    int n_bad = 0;
    bit seen_edge = 0;

    always #2 clk = ~clk;

    ea_gen_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_write(is_write),
        .op_lo(op_lo), .op_hi(op_hi), .ptr_word(ptr_word), .ptr_bank(ptr_bank),
        .reg_d(reg_d), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s), .reg_pc(reg_pc),
        .reg_db(reg_db), .reg_pb(reg_pb), .emu(emu), .idx8(idx8),
        .done(done), .ea(ea), .ptr_addr(ptr_addr), .ptr_wrap_pg(ptr_wrap_pg), .extra(extra)
    );

    // Reference state
    logic        r_done = 1'b0, r_pg = 1'b0;
    logic [23:0] r_ea = '0, r_pa = '0;
    logic [1:0]  r_ex = '0;
    int          r_mode = 0;

    function automatic void model(output int o_ea, output int o_pa, output int o_pg, output int o_ex);
        int xe, ye, dnz, pg, dsum, op16, pw, m, lo, off;
        xe   = idx8 ? (reg_x & 255) : reg_x;
        ye   = idx8 ? (reg_y & 255) : reg_y;
        dnz  = ((reg_d & 255) != 0) ? 1 : 0;
        pg   = (emu && dnz == 0) ? 1 : 0;
        dsum = (reg_d + op_lo) & 'hFFFF;
        op16 = op_hi * 256 + op_lo;
        pw   = ptr_word;
        m    = mode;
        o_ea = 0; o_pa = 0; o_pg = 0; o_ex = 0;
        case (m)
            0: o_ea = reg_db * 65536 + op16;
            1, 2: begin
                lo   = (m == 1) ? xe : ye;
                o_ea = (reg_db * 65536 + op16 + lo) & 'hFFFFFF;
                o_ex = (is_write || !idx8 || ((op16 & 255) + (lo & 255)) > 255) ? 1 : 0;
            end
            3: begin o_ea = dsum; o_ex = dnz; end
            4, 5, 7: begin
                lo = (m == 5) ? ye : xe;
                if (pg) lo = (dsum & 'hFF00) | ((dsum + lo) & 255);
                else    lo = (dsum + lo) & 'hFFFF;
                o_ex = dnz + 1;
                if (m == 7) begin o_pa = lo; o_pg = pg; o_ea = reg_db * 65536 + pw; end
                else o_ea = lo;
            end
            6: begin o_pa = dsum; o_pg = pg; o_ea = reg_db * 65536 + pw; o_ex = dnz; end
            8: begin
                o_pa = dsum; o_pg = pg;
                o_ea = (reg_db * 65536 + pw + ye) & 'hFFFFFF;
                o_ex = dnz + ((is_write || !idx8 || ((pw & 255) + (ye & 255)) > 255) ? 1 : 0);
            end
            9:  begin o_pa = dsum; o_ea = ptr_bank * 65536 + pw; o_ex = dnz; end
            10: begin o_pa = dsum; o_ea = (ptr_bank * 65536 + pw + ye) & 'hFFFFFF; o_ex = dnz; end
            11: begin o_ea = (reg_s + op_lo) & 'hFFFF; o_ex = 1; end
            12: begin
                o_pa = (reg_s + op_lo) & 'hFFFF;
                o_ea = (reg_db * 65536 + pw + ye) & 'hFFFFFF;
                o_ex = 2;
            end
            13: begin
                off  = (op_lo >= 128) ? (op_lo - 256) : op_lo;
                o_ea = reg_pb * 65536 + ((reg_pc + off) & 'hFFFF);
            end
            14: o_ea = reg_pb * 65536 + ((reg_pc + op16) & 'hFFFF);
            default: begin
                o_pa = reg_pb * 65536 + ((op16 + xe) & 'hFFFF);
                o_ea = reg_pb * 65536 + pw;
                o_ex = 1;
            end
        endcase
    endfunction

    function automatic string ea_tag(int m);
        case (m)
            0: return "R1";
            1, 2: return "R2";
            3: return "R4";
            4, 5: return "R5";
            6, 7, 8: return "R7";
            9, 10: return "R8";
            11, 12: return "R9";
            13, 14: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic string ex_tag(int m);
        case (m)
            1, 2, 8: return "R3";
            3, 4, 5, 6, 7, 9, 10: return "R4";
            11, 12: return "R9";
            15: return "R11";
            default: return "R1";
        endcase
    endfunction

    // Reference model update on the same edge as the design.
    always @(posedge clk) begin
        int a, p, g, x;
        seen_edge <= 1'b1;
        if (!rst_n) begin
            r_done <= 1'b0; r_ea <= '0; r_pa <= '0; r_pg <= 1'b0; r_ex <= '0; r_mode <= 0;
        end else begin
            r_done <= start;
            if (start) begin
                model(a, p, g, x);
                r_ea <= 24'(a); r_pa <= 24'(p); r_pg <= (g != 0); r_ex <= 2'(x);
                r_mode <= int'(mode);
            end
        end
    end

    task automatic chk(string tag, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp_v);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(rst_n ? "R12 done" : "R12 reset done", int'(done), int'(r_done));
            chk(rst_n ? ea_tag(r_mode) : "R12 reset ea", int'(ea), int'(r_ea));
            chk(rst_n ? ex_tag(r_mode) : "R12 reset extra", int'(extra), int'(r_ex));
            chk(r_mode == 15 ? "R11 ptr" : "R6 ptr", int'(ptr_addr), int'(r_pa));
            chk("R6 wrap", int'(ptr_wrap_pg), int'(r_pg));
        end
    end

    task automatic go(int m, int d, int x, int y, int o1, int o2, int pw, bit e, bit n8, bit w);
        @(negedge clk);
        mode = 4'(m); reg_d = 16'(d); reg_x = 16'(x); reg_y = 16'(y);
        op_lo = 8'(o1); op_hi = 8'(o2); ptr_word = 16'(pw);
        emu = e; idx8 = n8; is_write = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        reg_db = 8'h7E; reg_pb = 8'h12; reg_s = 16'h01F0; reg_pc = 16'h0004; ptr_bank = 8'h34;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5 page wrap vs full sum
        go(4, 16'h1200, 16'h0020, 0, 8'hF0, 0, 0, 1, 1, 0);
        go(4, 16'h1200, 16'h0020, 0, 8'hF0, 0, 0, 0, 1, 0);
        go(5, 16'h1201, 0, 16'h00FF, 8'h10, 0, 0, 1, 1, 0);
        // R3 carry boundary, both widths, store
        go(1, 0, 16'h0001, 0, 8'hFF, 8'h12, 0, 0, 1, 0);
        go(1, 0, 16'h0001, 0, 8'hFE, 8'h12, 0, 0, 1, 0);
        go(2, 0, 0, 16'h0100, 8'h00, 8'hFF, 0, 0, 0, 0);
        go(2, 0, 0, 16'h0001, 8'h00, 8'hFF, 0, 0, 1, 1);
        go(8, 16'h0000, 0, 16'h0080, 8'h02, 0, 16'h1280, 0, 1, 0);
        // R2 narrow index ignores the high byte
        go(1, 0, 16'hAB05, 0, 8'h10, 8'hFF, 0, 0, 1, 0);
        // R6 and R7 pointer wrap flag
        go(6, 16'h0300, 0, 0, 8'h40, 0, 16'hBEEF, 1, 1, 0);
        go(7, 16'h0300, 16'h00C5, 0, 8'h40, 0, 16'hBEEF, 1, 1, 0);
        go(6, 16'h0301, 0, 0, 8'h40, 0, 16'hBEEF, 1, 1, 0);
        // R8 long pointer with carry into the bank
        go(10, 16'h0010, 0, 16'h0200, 8'h01, 0, 16'hFF00, 0, 0, 0);
        // R9 stack forms
        go(11, 0, 0, 0, 8'h20, 0, 0, 0, 1, 0);
        go(12, 0, 0, 16'hFFFF, 8'h03, 0, 16'h0002, 0, 0, 0);
        // R10 negative offset wraps below zero, long branch
        go(13, 0, 0, 0, 8'hF0, 0, 0, 0, 1, 0);
        go(14, 0, 0, 0, 8'h00, 8'hFF, 0, 0, 1, 0);
        // R11 indexed indirect wraps within the bank
        go(15, 0, 16'h0010, 0, 8'hF8, 8'hFF, 16'h8000, 0, 0, 0);
        // R12 back-to-back starts, then random traffic
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            mode = 4'($urandom_range(0, 15));
            reg_d = 16'($urandom);
            if ($urandom_range(0, 1) == 1) reg_d[7:0] = 8'h00;
            reg_x = 16'($urandom); reg_y = 16'($urandom); reg_s = 16'($urandom);
            reg_pc = 16'($urandom); reg_db = 8'($urandom); reg_pb = 8'($urandom);
            op_lo = 8'($urandom); op_hi = 8'($urandom);
            ptr_word = 16'($urandom); ptr_bank = 8'($urandom);
            emu = 1'($urandom); idx8 = 1'($urandom); is_write = 1'($urandom);
            start = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R12 synchronous reset clears held outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule